// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when an asynchronous DRAM must be refreshed and keeps its memory controller away from the array until the part has powered up. Elaboration turns the clock frequency, the start-up delay and the refresh interval into cycle counts. After reset the block waits out the start-up delay. It then asks for a fixed number of dummy refresh cycles and only then reports that ordinary accesses may begin. From that point a periodic tick adds one refresh to a small saturating debt. The controller pays the debt off whenever it can fit a refresh between accesses.

The controller sees a level request, an urgency flag and a ready flag. It answers with a one-cycle grant when it starts a refresh and a one-cycle done pulse when that refresh has finished. A style input selects the kind of refresh at grant time. The first style drives a row address from an 11-bit row counter that the block keeps. The second lets the memory use its own internal counter, so no row is driven. Pin-level strobe timing belongs to the controller.

The state machine has five states. STARTUP counts the power-up delay. INIT_WAIT holds an initialization request open. INIT_RUN covers one granted initialization refresh. IDLE is normal operation with no refresh in flight, and RUN covers a granted normal refresh. The transitions are these. DELAY_OVER goes from STARTUP to INIT_WAIT when the delay expires. INIT_GRANT goes from INIT_WAIT to INIT_RUN. INIT_NEXT goes from INIT_RUN back to INIT_WAIT on a done that is not the last. INIT_LAST goes from INIT_RUN to IDLE on the final initialization done. REF_GRANT goes from IDLE to RUN when a grant arrives while debt is owed. REF_DONE goes from RUN to IDLE.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `ref_req`, `ref_urgent`, `init_done` and `row_valid` are 0 and `ref_row` is 0.
- R2: For the first STARTUP_CYC clock edges after reset is released, `ref_req` stays 0. STARTUP_CYC is CLK_MHZ*STARTUP_NS/1000. A grant or done pulse during this time has no effect: it neither starts a refresh nor counts toward initialization.
- R3: On clock edge STARTUP_CYC `ref_req` rises. It stays high until INIT_REFRESHES (default 8) grant/done pairs have completed. `init_done` rises on the edge of the last of these done pulses and not earlier.
- R4: A refresh tick comes every INTERVAL_CYC edges (CLK_MHZ*INTERVAL_NS/1000), counting from the edge on which `init_done` rose. No tick comes before that edge.
- R5: The refresh debt is 3 bits wide. Each tick adds one and each completed normal refresh removes one. The debt saturates at 7, so ticks beyond that are lost.
- R6: `ref_urgent` is 1 exactly while the debt is at least URGENT_LEVEL (default 4).
- R7: After initialization, `ref_req` is 1 while the debt is non-zero. It falls only on the done pulse that takes the debt to zero.
- R8: `ref_row` is an 11-bit counter. It advances by one on each completed refresh of style 0 (row-driven), including initialization refreshes, and wraps from 2047 to 0.
- R9: A refresh granted with `refresh_style`=1 (memory-internal counter) keeps `row_valid` at 0 while it is in flight and leaves `ref_row` unchanged. With style 0, `row_valid` is 1 from the cycle after the grant until the done edge.
- R10: A grant while `ref_req` is 0, or a done with no granted refresh in flight, is ignored: no refresh starts and `ref_row` does not change.
- R11: Once `init_done` is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_style | input | 1 | Style sampled with the grant: 0 row-driven, 1 memory-internal counter |
| ref_grant | input | 1 | One-cycle pulse: controller starts the requested refresh |
| ref_done | input | 1 | One-cycle pulse: controller finished the granted refresh |
| ref_req | output | 1 | Refresh wanted (initialization refresh or debt owed) |
| ref_urgent | output | 1 | Debt has reached the urgent level |
| init_done | output | 1 | Start-up delay and initialization refreshes complete; normal access allowed |
| row_valid | output | 1 | A row-driven refresh is in flight and `ref_row` is its row |
| ref_row | output | 11 | Row address for row-driven refresh |

## Verification
Directed sequences cover the exact edge on which the start-up delay ends. They also cover grant and done pulses that arrive during the delay or while nothing is owed, which separates a design that ignores them from one that counts them toward initialization. The debt is tested by withholding service for nine intervals. Paying it back one refresh at a time then shows the saturation point, the urgent threshold in both directions, and the single done pulse that lowers the request. A long run with seeded random styles and grant-to-done latencies follows. It checks after every completion that the row counter advances only for row-driven refreshes, and it drives the counter through its wrap from 2047 to 0.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [2:0] {
        ST_STARTUP,
        ST_INIT_WAIT,
        ST_INIT_RUN,
        ST_IDLE,
        ST_RUN
    } sched_state_t;

    // nanoseconds to clock cycles for an integer MHz clock
    function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
        return (mhz * ns) / 1000;
    endfunction

endpackage

// File: rtl/sched_period_timer.sv
module sched_period_timer #(
    parameter int unsigned PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pulse
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign pulse = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || pulse) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sched_debt_counter.sv
module sched_debt_counter #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned URGENT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [WIDTH-1:0] debt,
    output logic             pending,
    output logic             urgent
);
    localparam logic [WIDTH-1:0] FULL   = '1;
    localparam logic [WIDTH-1:0] URG_LV = WIDTH'(URGENT);

    logic [WIDTH-1:0] debt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else if (inc && !dec && debt_q != FULL) begin
            debt_q <= debt_q + 1'b1;
        end else if (dec && !inc && debt_q != '0) begin
            debt_q <= debt_q - 1'b1;
        end
    end

    assign debt    = debt_q;
    assign pending = (debt_q != '0);
    assign urgent  = (debt_q >= URG_LV);
endmodule

// File: rtl/sched_row_counter.sv
module sched_row_counter #(
    parameter int unsigned ROW_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [ROW_BITS-1:0] row
);
    logic [ROW_BITS-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (step) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign row = row_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import sched_pkg::*;
#(
    parameter int unsigned CLK_MHZ         = 250,
    parameter int unsigned STARTUP_NS      = 200000,
    parameter int unsigned INTERVAL_NS     = 15600,
    parameter int unsigned INIT_REFRESHES  = 8,
    parameter int unsigned ROW_BITS        = 11,
    parameter int unsigned DEBT_BITS       = 3,
    parameter int unsigned URGENT_LEVEL    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refresh_style,
    input  logic                ref_grant,
    input  logic                ref_done,
    output logic                ref_req,
    output logic                ref_urgent,
    output logic                init_done,
    output logic                row_valid,
    output logic [ROW_BITS-1:0] ref_row
);
    localparam int unsigned STARTUP_CYC  = ns_to_cycles(CLK_MHZ, STARTUP_NS);
    localparam int unsigned INTERVAL_CYC = ns_to_cycles(CLK_MHZ, INTERVAL_NS);
    localparam int unsigned IW           = $clog2(INIT_REFRESHES + 1);
    localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_REFRESHES - 1);

    sched_state_t state_q, state_d;

    logic            startup_pulse;
    logic            tick;
    logic            run_cbr_q;
    logic [IW-1:0]   init_cnt_q;
    logic [DEBT_BITS-1:0] debt;
    logic            debt_pending;
    logic            debt_urgent;
    logic            grant_take;
    logic            init_finish;
    logic            norm_finish;
    logic            row_step;
    logic            in_normal;

    // ---- timers -------------------------------------------------------
    sched_period_timer #(.PERIOD(STARTUP_CYC)) u_startup_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_STARTUP),
        .pulse (startup_pulse)
    );

    sched_period_timer #(.PERIOD(INTERVAL_CYC)) u_interval_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_normal),
        .pulse (tick)
    );

    // ---- debt and row -------------------------------------------------
    sched_debt_counter #(.WIDTH(DEBT_BITS), .URGENT(URGENT_LEVEL)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (norm_finish),
        .debt    (debt),
        .pending (debt_pending),
        .urgent  (debt_urgent)
    );

    sched_row_counter #(.ROW_BITS(ROW_BITS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_step),
        .row   (ref_row)
    );

    // ---- event decode -------------------------------------------------
    assign in_normal   = (state_q == ST_IDLE) || (state_q == ST_RUN);
    assign grant_take  = ref_grant &&
                         ((state_q == ST_INIT_WAIT) || (state_q == ST_IDLE && debt_pending));
    assign init_finish = (state_q == ST_INIT_RUN) && ref_done;
    assign norm_finish = (state_q == ST_RUN) && ref_done;
    assign row_step    = (init_finish || norm_finish) && !run_cbr_q;

    // ---- state register -----------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STARTUP;
        end else begin
            state_q <= state_d;
        end
    end

    // ---- next state ---------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STARTUP:   if (startup_pulse) state_d = ST_INIT_WAIT;       // DELAY_OVER
            ST_INIT_WAIT: if (ref_grant)     state_d = ST_INIT_RUN;        // INIT_GRANT
            ST_INIT_RUN:  if (ref_done) begin
                              if (init_cnt_q == INIT_LAST) state_d = ST_IDLE; // INIT_LAST
                              else                         state_d = ST_INIT_WAIT; // INIT_NEXT
                          end
            ST_IDLE:      if (ref_grant && debt_pending) state_d = ST_RUN; // REF_GRANT
            ST_RUN:       if (ref_done)      state_d = ST_IDLE;            // REF_DONE
            default:      state_d = ST_STARTUP;
        endcase
    end

    // ---- per-refresh bookkeeping --------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cbr_q  <= 1'b0;
            init_cnt_q <= '0;
        end else begin
            if (grant_take) begin
                run_cbr_q <= refresh_style;
            end
            if (init_finish) begin
                init_cnt_q <= init_cnt_q + 1'b1;
            end
        end
    end

    // ---- outputs ------------------------------------------------------
    always_comb begin
        ref_req    = 1'b0;
        ref_urgent = 1'b0;
        init_done  = 1'b0;
        row_valid  = 1'b0;
        unique case (state_q)
            ST_STARTUP: ;
            ST_INIT_WAIT: ref_req = 1'b1;
            ST_INIT_RUN: begin
                ref_req   = 1'b1;
                row_valid = !run_cbr_q;
            end
            ST_IDLE: begin
                init_done  = 1'b1;
                ref_req    = debt_pending;
                ref_urgent = debt_urgent;
            end
            ST_RUN: begin
                init_done  = 1'b1;
                ref_req    = debt_pending;
                ref_urgent = debt_urgent;
                row_valid  = !run_cbr_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int unsigned STARTUP_CYC = 100,
    parameter int unsigned ROW_BITS    = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ref_req,
    input logic                ref_urgent,
    input logic                init_done,
    input logic                row_valid,
    input logic                ref_done,
    input logic [ROW_BITS-1:0] ref_row
);
    int unsigned since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 0;
        end else if (since_rst < STARTUP_CYC) begin
            since_rst <= since_rst + 1;
        end
    end

    assert_quiet_startup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < STARTUP_CYC) |-> !ref_req);

    assert_init_asks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == STARTUP_CYC && !init_done) |-> ref_req);

    assert_urgent_has_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    assert_row_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_row) |-> (ref_row == ROW_BITS'($past(ref_row) + 1'b1)));

    assert_row_moves_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_row) |-> $past(row_valid && ref_done));

    assert_ready_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind dram_refresh_sched sched_checker #(
    .STARTUP_CYC (STARTUP_CYC),
    .ROW_BITS    (ROW_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .init_done  (init_done),
    .row_valid  (row_valid),
    .ref_done   (ref_done),
    .ref_row    (ref_row)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int STARTUP = 100;   // 250 MHz * 400 ns
    localparam int IVL     = 25;    // 250 MHz * 100 ns
    localparam int ROWS    = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        refresh_style = 1'b0;
    logic        ref_grant = 1'b0;
    logic        ref_done = 1'b0;
    logic        ref_req, ref_urgent, init_done, row_valid;
    logic [10:0] ref_row;

    int checks = 0;
    int errors = 0;
    int exp_row = 0;
    bit finished = 1'b0;
    bit wrapped = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .CLK_MHZ(250), .STARTUP_NS(400), .INTERVAL_NS(100)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_style(refresh_style),
        .ref_grant(ref_grant), .ref_done(ref_done), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .init_done(init_done),
        .row_valid(row_valid), .ref_row(ref_row)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_row(input int r, input bit cbr);
        return cbr ? r : (r + 1) % ROWS;
    endfunction

    // wait for a request, grant, hold lat cycles, then done; all at negedges
    task automatic do_refresh(input bit cbr, input int lat, input string tag);
        while (!ref_req) @(negedge clk);
        refresh_style = cbr;
        ref_grant = 1'b1;
        @(negedge clk);
        ref_grant = 1'b0;
        check(row_valid == !cbr, tag, row_valid, !cbr);
        check(ref_row == exp_row, tag, ref_row, exp_row);
        repeat (lat) @(negedge clk);
        ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;
        if (!cbr && exp_row == ROWS - 1) wrapped = 1'b1;
        exp_row = next_row(exp_row, cbr);
        check(ref_row == exp_row, tag, ref_row, exp_row);
        check(row_valid == 1'b0, tag, row_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset values
        check(ref_req == 0,    "R1 req",    ref_req, 0);
        check(ref_urgent == 0, "R1 urgent", ref_urgent, 0);
        check(init_done == 0,  "R1 ready",  init_done, 0);
        check(row_valid == 0,  "R1 rowvld", row_valid, 0);
        check(ref_row == 0,    "R1 row",    ref_row, 0);
        rst_n = 1'b1;

        // R2 grant and done during start-up are ignored
        repeat (10) @(negedge clk);
        ref_grant = 1'b1;
        @(negedge clk);
        ref_grant = 1'b0;
        ref_done = 1'b1;
        check(row_valid == 0, "R2 grant ignored", row_valid, 0);
        @(negedge clk);
        ref_done = 1'b0;
        check(ref_row == 0, "R2 done ignored", ref_row, 0);
        repeat (STARTUP - 1 - 12) @(negedge clk);
        check(ref_req == 0, "R2 quiet until delay", ref_req, 0);
        @(negedge clk);
        check(ref_req == 1, "R3 request after delay", ref_req, 1);

        // R3 eight init refreshes, alternating style (R8, R9)
        for (int i = 0; i < 8; i++) begin
            if (i == 7) check(init_done == 0, "R3 not ready before 8th", init_done, 0);
            do_refresh(i[0], i % 3, "R3/R8/R9 init refresh");
        end
        check(init_done == 1, "R3 ready after 8th", init_done, 1);
        check(ref_req == 0,   "R7 nothing owed", ref_req, 0);
        check(ref_row == 4,   "R8 four row-driven inits", ref_row, 4);

        // R10 stray grant/done with nothing owed
        ref_grant = 1'b1;
        @(negedge clk);
        ref_grant = 1'b0;
        ref_done = 1'b1;
        check(row_valid == 0, "R10 stray grant", row_valid, 0);
        @(negedge clk);
        ref_done = 1'b0;
        check(ref_row == exp_row, "R10 stray done", ref_row, exp_row);

        // R4 first tick exactly one interval after ready
        repeat (IVL - 3) @(negedge clk);
        check(ref_req == 0, "R4 no tick early", ref_req, 0);
        @(negedge clk);
        check(ref_req == 1, "R4 tick on time", ref_req, 1);

        // R6 urgent threshold while debt builds
        repeat (3 * IVL - 1) @(negedge clk);
        check(ref_urgent == 0, "R6 debt 3 not urgent", ref_urgent, 0);
        @(negedge clk);
        check(ref_urgent == 1, "R6 debt 4 urgent", ref_urgent, 1);
        check(init_done == 1, "R11 ready held", init_done, 1);

        // R5 saturation: nine intervals elapsed, only seven owed
        repeat (5 * IVL) @(negedge clk);
        for (int i = 1; i <= 7; i++) begin
            do_refresh(1'b0, 1, "R5/R8 pay debt");
            check(ref_urgent == (7 - i >= 4), "R6 urgent while paying", ref_urgent, (7 - i >= 4));
            if (i < 7) check(ref_req == 1, "R7 req held while owed", ref_req, 1);
        end
        check(ref_req == 0, "R5/R7 debt saturated at 7", ref_req, 0);

        // random service: styles and latencies, row counter wrap (R8, R9)
        for (int n = 0; n < 2800; n++) begin
            bit cbr;
            int lat;
            cbr = ($urandom % 8) == 0;
            lat = $urandom % 4;
            do_refresh(cbr, lat, cbr ? "R9 random internal-counter" : "R8 random row-driven");
        end
        check(wrapped == 1, "R8 row wrap seen", wrapped, 1);
        check(init_done == 1, "R11 ready sticky", init_done, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule